// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine with Cyclic Reload

This block is one DMA channel that sits between a peripheral's data register and system memory. Each accepted transfer request moves a single unit, a byte or a 16-bit word, as a read followed by a write on a simple memory bus master port. The request line that fired selects the direction. A receive request copies the peripheral register into memory. A transmit request copies memory into the peripheral register. An external-pin request goes the way a configuration bit selects. When an internal peripheral's request is taken, the channel pulses a clear to that peripheral's status flag, so the CPU never sees an interrupt for that event.

Software programs the channel with one configuration write. That write sets the memory address, an 8-bit transfer count, the operating mode, the unit size, the direction for the external pin, the enable and the interrupt enable. In stepping mode the memory address advances after each unit. Fixed-address mode keeps one memory location, which suits a data port that is read or written over and over. Cyclic mode keeps shadow copies of the start address and count. When a pass ends, it restores them and keeps running until software clears the enable. Only the two non-cyclic modes finish, stop themselves and may raise a completion interrupt.

Top module: `pdma_chan`

## Requirements
- R1: Each accepted request causes exactly one bus read, then exactly one bus write of a single unit, and decrements the working count by one.
- R2: Direction follows the request source. `int_rx_req` reads address `PERIPH_ADDR` and writes the memory address. `int_tx_req` reads the memory address and writes `PERIPH_ADDR`. `ext_req` behaves like a receive when `cfg_ext_dir`=0 and like a transmit when it is 1.
- R3: With `cfg_word`=1 the unit is 16 bits and `m_word`=1. With `cfg_word`=0 the unit is a byte, `m_word`=0, and the written data has its upper 8 bits forced to zero.
- R4: In stepping mode (`cfg_mode`=00, and also the unused code 11) the memory address grows by 1 after a byte and by 2 after a word.
- R5: In fixed-address mode (`cfg_mode`=01) the memory address never changes.
- R6: In cyclic mode (`cfg_mode`=10), the transfer that exhausts the count restores the programmed address and count, the channel stays enabled, and `irq` is never raised.
- R7: The count is 8 bits wide, and a programmed value of 0 means 256 transfers.
- R8: In stepping and fixed-address modes, the last transfer clears the enable, so later requests cause no bus activity. If the interrupt enable is set, that last transfer also produces a one-cycle `irq` pulse.
- R9: Taking an internal request pulses `src_clr` for one cycle (bit 0 for receive, bit 1 for transmit). Taking an external-pin request pulses neither bit.
- R10: Requests are latched as pending and serviced one at a time. When several are pending, receive wins over transmit, and transmit wins over external.
- R11: Requests that arrive while the channel is disabled are dropped and cause no bus activity.
- R12: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_write` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; loads every cfg_* field and drops pending requests |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Transfers per pass (0 means 2^CW) |
| cfg_mode | input | 2 | 00 stepping, 01 fixed address, 10 cyclic, 11 stepping |
| cfg_word | input | 1 | 1 = 16-bit units, 0 = bytes |
| cfg_ext_dir | input | 1 | External-pin direction: 0 receive, 1 transmit |
| cfg_en | input | 1 | Channel enable |
| cfg_irq_en | input | 1 | Completion interrupt enable |
| int_rx_req | input | 1 | Internal peripheral has data ready (receive) |
| int_tx_req | input | 1 | Internal peripheral needs data (transmit) |
| ext_req | input | 1 | External pin request strobe |
| m_valid | output | 1 | Bus access valid |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | AW | Bus address |
| m_word | output | 1 | Access size, 1 = word |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid with m_ready on a read |
| m_ready | input | 1 | Bus completes the current access |
| src_clr | output | 2 | One-cycle clear of the requesting peripheral's flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The checker relies on two promises about the inputs. First, software writes the configuration only while no access is in flight, because a write in mid-transfer could move the memory address under a stalled access and could swap the mode beneath a pending completion. Second, the bus never withdraws `m_ready` in a way that needs `m_valid` to drop. The bench keeps to these rules. It issues every configuration write after draining its expected-write queue, and it drives `m_ready` from a free-running pattern that stalls one access cycle in four without ever depending on the design's state.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic [1:0] {
      MODE_STEP  = 2'b00,
      MODE_FIXED = 2'b01,
      MODE_CYCLE = 2'b10,
      MODE_STEP2 = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'b00,
      ST_READ  = 2'b01,
      ST_WRITE = 2'b10
   } st_e;

   localparam int SRC_RX  = 0;
   localparam int SRC_TX  = 1;
   localparam int SRC_EXT = 2;
   localparam int NSRC    = 3;

endpackage

// File: rtl/pdma_req_latch.sv
module pdma_req_latch #(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic            enable,
   input  logic            flush,
   input  logic            take,
   output logic            pend_any,
   output logic [NSRC-1:0] grant
);

   logic [NSRC-1:0] pend_q;

   initial begin
      assert (NSRC >= 1) else $error("pdma_req_latch: NSRC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         for (int k = 0; k < NSRC; k++) begin
            if (flush)                 pend_q[k] <= 1'b0;
            else if (enable && req[k]) pend_q[k] <= 1'b1;
            else if (take && grant[k]) pend_q[k] <= 1'b0;
         end
      end
   end

   // lowest index has the highest priority
   always_comb begin
      grant = '0;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (pend_q[k]) begin
            grant    = '0;
            grant[k] = 1'b1;
         end
      end
   end

   assign pend_any = |pend_q;

endmodule

// File: rtl/pdma_count.sv
module pdma_count #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          cyclic,
   output logic          last
);

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] shad_q;

   initial begin
      assert (CW >= 2) else $error("pdma_count: CW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         shad_q <= '0;
      end else if (load) begin
         cnt_q  <= load_val;
         shad_q <= load_val;
      end else if (step) begin
         if (last && cyclic) cnt_q <= shad_q;
         else                cnt_q <= cnt_q - ONE;
      end
   end

   // a loaded zero wraps to all ones, giving 2^CW transfers
   assign last = (cnt_q == ONE);

endmodule

// File: rtl/pdma_addr.sv
module pdma_addr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          hold,
   input  logic          reload,
   input  logic          word,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] addr_q;
   logic [AW-1:0] shad_q;
   logic [AW-1:0] inc;

   initial begin
      assert (AW >= 2) else $error("pdma_addr: AW must be at least 2");
   end

   assign inc = word ? AW'(2) : AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         shad_q <= '0;
      end else if (load) begin
         addr_q <= load_val;
         shad_q <= load_val;
      end else if (step) begin
         if (reload)     addr_q <= shad_q;
         else if (!hold) addr_q <= addr_q + inc;
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter int              AW          = 16,
   parameter int              DW          = 16,
   parameter int              CW          = 8,
   parameter logic [AW-1:0]   PERIPH_ADDR = 16'hFF00,
   parameter bit              WORD_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [CW-1:0] cfg_count,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_word,
   input  logic          cfg_ext_dir,
   input  logic          cfg_en,
   input  logic          cfg_irq_en,
   input  logic          int_rx_req,
   input  logic          int_tx_req,
   input  logic          ext_req,
   output logic          m_valid,
   output logic          m_write,
   output logic [AW-1:0] m_addr,
   output logic          m_word,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ready,
   output logic [1:0]    src_clr,
   output logic          irq
);

   initial begin
      assert (DW >= 8) else $error("pdma_chan: DW must be at least 8");
      assert (!WORD_EN || DW >= 16) else $error("pdma_chan: word units need DW >= 16");
   end

   mode_e           mode_q;
   logic            word_q, ext_dir_q, en_q, irq_en_q;
   st_e             state_q;
   logic            dir_tx_q;
   logic [DW-1:0]   data_q;
   logic [1:0]      src_clr_q;
   logic            irq_q;

   logic [NSRC-1:0] req_v, grant;
   logic            pend_any, take, grant_tx, is_cyc, is_fixed;
   logic            xfer_done, last, size_w;
   logic [AW-1:0]   mem_addr;

   assign req_v     = {ext_req, int_tx_req, int_rx_req};
   assign take      = (state_q == ST_WAIT) && en_q && pend_any && !cfg_we;
   assign grant_tx  = grant[SRC_TX] | (grant[SRC_EXT] & ext_dir_q);
   assign is_cyc    = (mode_q == MODE_CYCLE);
   assign is_fixed  = (mode_q == MODE_FIXED);
   assign xfer_done = (state_q == ST_WRITE) && m_ready;

   generate
      if (WORD_EN) begin : g_size_sel
         assign size_w = word_q;
      end else begin : g_size_byte
         assign size_w = 1'b0;
      end
   endgenerate

   pdma_req_latch #(.NSRC(NSRC)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_v),
      .enable   (en_q),
      .flush    (cfg_we),
      .take     (take),
      .pend_any (pend_any),
      .grant    (grant)
   );

   pdma_count #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we),
      .load_val (cfg_count),
      .step     (xfer_done),
      .cyclic   (is_cyc),
      .last     (last)
   );

   pdma_addr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we),
      .load_val (cfg_addr),
      .step     (xfer_done),
      .hold     (is_fixed),
      .reload   (is_cyc && last),
      .word     (size_w),
      .addr     (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_STEP;
         word_q    <= 1'b0;
         ext_dir_q <= 1'b0;
         en_q      <= 1'b0;
         irq_en_q  <= 1'b0;
      end else if (cfg_we) begin
         mode_q    <= mode_e'(cfg_mode);
         word_q    <= cfg_word;
         ext_dir_q <= cfg_ext_dir;
         en_q      <= cfg_en;
         irq_en_q  <= cfg_irq_en;
      end else if (xfer_done && last && !is_cyc) begin
         en_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_WAIT;
         dir_tx_q  <= 1'b0;
         data_q    <= '0;
         src_clr_q <= 2'b00;
         irq_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_WAIT: if (take) begin
               state_q  <= ST_READ;
               dir_tx_q <= grant_tx;
            end
            ST_READ: if (m_ready) begin
               data_q  <= m_rdata;
               state_q <= ST_WRITE;
            end
            ST_WRITE: if (m_ready) state_q <= ST_WAIT;
            default: state_q <= ST_WAIT;
         endcase
         src_clr_q <= take ? grant[SRC_TX:SRC_RX] : 2'b00;
         irq_q     <= !cfg_we && xfer_done && last && !is_cyc && irq_en_q;
      end
   end

   assign m_valid = (state_q != ST_WAIT);
   assign m_write = (state_q == ST_WRITE);
   assign m_word  = size_w;
   assign m_addr  = (m_write ^ dir_tx_q) ? mem_addr : PERIPH_ADDR;

   generate
      if (DW > 8) begin : g_wmask
         assign m_wdata = size_w ? data_q : {{(DW-8){1'b0}}, data_q[7:0]};
      end else begin : g_wpass
         assign m_wdata = data_q;
      end
   endgenerate

   assign src_clr = src_clr_q;
   assign irq     = irq_q;

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          m_valid,
   input logic          m_write,
   input logic          m_ready,
   input logic [AW-1:0] m_addr,
   input logic [1:0]    src_clr,
   input logic          irq,
   input logic [1:0]    mode_q,
   input logic [AW-1:0] mem_addr,
   input logic          en_q
);

   p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

   p_write_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_write && m_ready) |=> (m_valid && m_write));

   p_fixed_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && !cfg_we) |=> $stable(mem_addr));

   p_no_irq_cyclic_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b10) |-> !irq);

   p_done_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !en_q);

   p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_clr));

   p_clr_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clr != 2'b00) |-> (m_valid && !m_write));

endmodule

bind pdma_chan pdma_chan_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .m_valid  (m_valid),
   .m_write  (m_write),
   .m_ready  (m_ready),
   .m_addr   (m_addr),
   .src_clr  (src_clr),
   .irq      (irq),
   .mode_q   (mode_q),
   .mem_addr (mem_addr),
   .en_q     (en_q)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;

   localparam int            AW     = 16;
   localparam int            DW     = 16;
   localparam int            CW     = 8;
   localparam logic [15:0]   PADDR  = 16'hFF00;
   localparam logic [15:0]   SCRAMB = 16'h5A3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [1:0]    cfg_mode = 2'b00;
   logic          cfg_word = 1'b0, cfg_ext_dir = 1'b0, cfg_en = 1'b0, cfg_irq_en = 1'b0;
   logic          int_rx_req = 1'b0, int_tx_req = 1'b0, ext_req = 1'b0;
   logic          m_valid, m_write, m_word, irq;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata, m_rdata;
   logic          m_ready = 1'b0;
   logic [1:0]    src_clr;
   logic [15:0]   periph_val = '0;
   logic [7:0]    rdy_cnt = '0;

   typedef struct {
      logic [15:0] addr;
      logic [15:0] data;
      logic        word;
   } item_t;

   item_t exp_q[$];
   int    n_chk = 0, n_fail = 0;
   int    irq_cnt = 0, clr_rx = 0, clr_tx = 0, act_cnt = 0, wr_cnt = 0;
   string cur_tag = "R1";
   logic          prev_stall = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   always #10 clk = ~clk;   // 20 time units per cycle: 50 MHz

   pdma_chan #(.AW(AW), .DW(DW), .CW(CW), .PERIPH_ADDR(PADDR), .WORD_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_word(cfg_word),
      .cfg_ext_dir(cfg_ext_dir), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
      .int_rx_req(int_rx_req), .int_tx_req(int_tx_req), .ext_req(ext_req),
      .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_word(m_word),
      .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
      .src_clr(src_clr), .irq(irq)
   );

   // bus model: stalls one cycle in four, reads return a fixed function of address
   always @(posedge clk) begin
      rdy_cnt <= rdy_cnt + 8'd1;
      m_ready <= (rdy_cnt[1:0] != 2'b11);
   end
   assign m_rdata = (m_addr == PADDR) ? periph_val : (m_addr ^ SCRAMB);

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: scoreboard comparison of every bus write
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_valid) act_cnt++;
         if (irq) irq_cnt++;
         if (src_clr[0]) clr_rx++;
         if (src_clr[1]) clr_tx++;
         if (prev_stall) begin
            check("R12", "held valid", {31'd0, m_valid}, 32'd1);
            check("R12", "held address", {16'd0, m_addr}, {16'd0, prev_addr});
         end
         prev_stall = m_valid && !m_ready;
         prev_addr  = m_addr;
         if (m_valid && m_write && m_ready) begin
            wr_cnt++;
            if (exp_q.size() == 0) begin
               check(cur_tag, "unexpected write at", {16'd0, m_addr}, 32'hFFFF_FFFF);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               check(cur_tag, "write address", {16'd0, m_addr}, {16'd0, e.addr});
               check(cur_tag, "write data", {16'd0, m_wdata}, {16'd0, e.data});
               check("R3", "write size", {31'd0, m_word}, {31'd0, e.word});
            end
         end
      end
   end

   task automatic configure(input logic [15:0] a, input logic [7:0] c, input logic [1:0] md,
                            input logic wd, input logic xd, input logic en, input logic ie);
      @(negedge clk);
      cfg_addr = a; cfg_count = c; cfg_mode = md; cfg_word = wd;
      cfg_ext_dir = xd; cfg_en = en; cfg_irq_en = ie; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic rx, input logic tx, input logic ex);
      @(negedge clk);
      int_rx_req = rx; int_tx_req = tx; ext_req = ex;
      @(negedge clk);
      int_rx_req = 1'b0; int_tx_req = 1'b0; ext_req = 1'b0;
   endtask

   // driver side: push expected items
   task automatic push_rx(input logic [15:0] a, input logic wd);
      item_t e;
      e.addr = a; e.word = wd;
      e.data = wd ? periph_val : {8'h00, periph_val[7:0]};
      exp_q.push_back(e);
   endtask

   task automatic push_tx(input logic [15:0] a, input logic wd);
      item_t e;
      logic [15:0] v;
      v = a ^ SCRAMB;
      e.addr = PADDR; e.word = wd;
      e.data = wd ? v : {8'h00, v[7:0]};
      exp_q.push_back(e);
   endtask

   task automatic drain();
      for (int t = 0; t < 400 && exp_q.size() != 0; t++) @(negedge clk);
      check(cur_tag, "items left in queue", exp_q.size(), 32'd0);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      finish_run();
   end

   initial begin
      int irq0, clr0, act0, wr0;
      repeat (3) @(negedge clk);
      // reset state
      check("R1", "reset m_valid", {31'd0, m_valid}, 32'd0);
      check("R8", "reset irq", {31'd0, irq}, 32'd0);
      check("R9", "reset src_clr", {30'd0, src_clr}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // stepping mode, word receive, three transfers
      cur_tag = "R4";
      configure(16'h0100, 8'd3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
      irq0 = irq_cnt; clr0 = clr_rx; wr0 = wr_cnt;
      for (int k = 0; k < 3; k++) begin
         periph_val = 16'h1234 + 16'(k);
         push_rx(16'h0100 + 16'(2 * k), 1'b1);
         pulse(1'b1, 1'b0, 1'b0);
         drain();
      end
      check("R1", "writes for three requests", wr_cnt - wr0, 32'd3);
      check("R8", "completion irq", irq_cnt - irq0, 32'd1);
      check("R9", "receive flag clears", clr_rx - clr0, 32'd3);
      act0 = act_cnt;
      pulse(1'b1, 1'b0, 1'b0);
      repeat (12) @(negedge clk);
      check("R8", "bus activity after self-disable", act_cnt - act0, 32'd0);

      // stepping mode, byte transmit, odd start
      cur_tag = "R3";
      configure(16'h0041, 8'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
      irq0 = irq_cnt; clr0 = clr_tx;
      for (int k = 0; k < 2; k++) begin
         push_tx(16'h0041 + 16'(k), 1'b0);
         pulse(1'b0, 1'b1, 1'b0);
         drain();
      end
      check("R9", "transmit flag clears", clr_tx - clr0, 32'd2);
      check("R8", "byte run irq", irq_cnt - irq0, 32'd1);

      // fixed-address mode, irq disabled
      cur_tag = "R5";
      configure(16'h0500, 8'd3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
      irq0 = irq_cnt;
      for (int k = 0; k < 3; k++) begin
         periph_val = 16'hC000 + 16'(k);
         push_rx(16'h0500, 1'b1);
         pulse(1'b1, 1'b0, 1'b0);
         drain();
      end
      check("R8", "no irq when disabled", irq_cnt - irq0, 32'd0);

      // cyclic mode
      cur_tag = "R6";
      configure(16'h0200, 8'd2, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1);
      irq0 = irq_cnt;
      for (int k = 0; k < 5; k++) begin
         periph_val = 16'h7700 + 16'(k);
         push_rx((k % 2 == 0) ? 16'h0200 : 16'h0202, 1'b1);
         pulse(1'b1, 1'b0, 1'b0);
         drain();
      end
      check("R6", "cyclic irq count", irq_cnt - irq0, 32'd0);
      cur_tag = "R11";
      configure(16'h0200, 8'd2, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1);
      act0 = act_cnt;
      pulse(1'b1, 1'b1, 1'b1);
      repeat (12) @(negedge clk);
      check("R11", "activity while disabled", act_cnt - act0, 32'd0);

      // external pin, both directions
      cur_tag = "R2";
      configure(16'h0600, 8'd2, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
      clr0 = clr_rx + clr_tx;
      push_tx(16'h0600, 1'b1);
      pulse(1'b0, 1'b0, 1'b1);
      drain();
      check("R9", "no clear for external", clr_rx + clr_tx - clr0, 32'd0);
      configure(16'h0602, 8'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
      periph_val = 16'h3C3C;
      push_rx(16'h0602, 1'b1);
      pulse(1'b0, 1'b0, 1'b1);
      drain();

      // priority among simultaneous requests
      cur_tag = "R10";
      configure(16'h0300, 8'd3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
      irq0 = irq_cnt;
      periph_val = 16'h9A9A;
      push_rx(16'h0300, 1'b1);
      push_tx(16'h0302, 1'b1);
      push_rx(16'h0304, 1'b1);
      pulse(1'b1, 1'b1, 1'b1);
      drain();
      check("R10", "irq after three pending", irq_cnt - irq0, 32'd1);

      // count of zero means 256
      cur_tag = "R7";
      configure(16'h0700, 8'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
      irq0 = irq_cnt;
      for (int k = 0; k < 255; k++) begin
         periph_val = 16'hAB00 | 16'(k);
         push_rx(16'h0700, 1'b0);
         pulse(1'b1, 1'b0, 1'b0);
         drain();
      end
      check("R7", "irq before 256th", irq_cnt - irq0, 32'd0);
      periph_val = 16'hABFF;
      push_rx(16'h0700, 1'b0);
      pulse(1'b1, 1'b0, 1'b0);
      drain();
      check("R7", "irq after 256th", irq_cnt - irq0, 32'd1);

      finish_run();
   end

endmodule